// File: doc/BRIEF.md
# Frequency Window Lock Detector

This block watches the divided-down output of a recovered-clock oscillator and decides whether its frequency lies within a loose tolerance band around the target. The band defaults to plus or minus 1000 ppm. The only timebase it uses is a reference clock, at 19.44 MHz or 38.88 MHz. A mode input selects which one is present. Each rising edge of the divided oscillator clock reaches the block as a one-cycle pulse that has already been brought into the reference domain. The block counts these pulses over a gate of a fixed number of reference cycles. When the gate closes, it compares the total against an expected count plus or minus a tolerance, both computed at elaboration.

A gate that lands outside the band turns off the phase detector. It also raises a steering command: steer up when the count is low, steer down when it is high. This pulls the oscillator back toward the target. The first gate that lands inside the band drops the steering and turns the phase detector back on, so phase acquisition starts again. One further full in-window gate declares lock. Any out-of-window gate at any time returns the block to steering.

Top module: `freq_window_det`

## Requirements
- R1: While reset is low, and just after it is released, pd_enable, locked, steer_up and steer_down are all 0, and the controller is in its steering state with no steering direction.
- R2: A gate spans GATE_CYCLES reference cycles and starts at the first clock edge after reset is released. A pulse present at any edge of the gate counts, the closing edge included. The outputs change only at the edge that closes a gate.
- R3: Every pulse counts as one, whatever its spacing. With ref_sel = 0 the expected count is GATE_CYCLES/SLOW_DIV. With ref_sel = 1 it is GATE_CYCLES/FAST_DIV. The tolerance is floor(expected × TOL_PPM / 1,000,000). A count is in window when it lies within the inclusive range [expected − tolerance, expected + tolerance].
- R4: A gate whose count is below the range drives the block to steering with steer_up = 1, steer_down = 0 and pd_enable = 0.
- R5: A gate whose count is above the range drives the block to steering with steer_down = 1, steer_up = 0 and pd_enable = 0.
- R6: An in-window gate closed while steering moves the block to measuring: pd_enable = 1, both steering outputs 0, locked = 0.
- R7: An in-window gate closed while measuring sets locked = 1. Further in-window gates keep it set.
- R8: An out-of-window gate closed while measuring or locked clears pd_enable and locked at that same edge.
- R9: steer_up and steer_down are never 1 together. Neither is 1 while pd_enable is 1. locked = 1 implies pd_enable = 1.
- R10: The mode is taken from ref_sel as it stands in the cycle that closes the gate. Its value earlier in the gate has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| ref_sel | input | 1 | Reference mode: 0 = 19.44 MHz, 1 = 38.88 MHz |
| div_edge | input | 1 | One-cycle pulse per edge of the divided oscillator clock |
| pd_enable | output | 1 | Phase detector enable |
| steer_up | output | 1 | Command to raise the oscillator frequency |
| steer_down | output | 1 | Command to lower the oscillator frequency |
| locked | output | 1 | Frequency held in window for a full confirming gate |

## Verification
The bench builds the block with GATE_CYCLES = 256 and TOL_PPM = 50000. The dividers stay at their defaults, giving an expected count of 128 ± 6 in the slow mode and 64 ± 3 in the fast mode. At these values every window edge is a whole count that a short burst can hit exactly. Each bound is exercised one count inside and one count outside, in both modes, and each state transition takes only a few hundred cycles. A mode switch within the final cycle of a gate makes R10 observable: the same count is in window in one mode and far out of window in the other.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    ST_STEER   = 2'd0,
    ST_MEASURE = 2'd1,
    ST_TRACK   = 2'd2
  } fwd_state_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } fwd_dir_e;

  typedef struct packed {
    logic too_low;
    logic too_high;
  } fwd_verdict_t;

endpackage

// File: rtl/fwd_gate_timer.sv
module fwd_gate_timer #(
  parameter int GATE_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_end
);
  localparam int TW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

  logic [TW-1:0] tmr_q, tmr_d;

  assign gate_end = (tmr_q == LAST);

  always_comb begin
    if (gate_end) tmr_d = '0;
    else          tmr_d = tmr_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end
endmodule

// File: rtl/fwd_edge_counter.sv
module fwd_edge_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_pulse,
  input  logic             gate_end,
  output logic [CNT_W-1:0] gate_total
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign gate_total = cnt_q + CNT_W'(edge_pulse);

  always_comb begin
    if (gate_end) cnt_d = '0;
    else          cnt_d = gate_total;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fwd_window_cmp.sv
module fwd_window_cmp
  import fwd_pkg::*;
#(
  parameter int CNT_W       = 17,
  parameter int GATE_CYCLES = 65536,
  parameter int SLOW_DIV    = 2,
  parameter int FAST_DIV    = 4,
  parameter int TOL_PPM     = 1000
) (
  input  logic             mode_sel,
  input  logic [CNT_W-1:0] gate_total,
  output fwd_verdict_t     verdict
);
  logic [CNT_W-1:0] lo_bound [2];
  logic [CNT_W-1:0] hi_bound [2];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam int DIVR     = (m == 0) ? SLOW_DIV : FAST_DIV;
    localparam longint EXPC = longint'(GATE_CYCLES / DIVR);
    localparam longint TOLC = (EXPC * longint'(TOL_PPM)) / 64'sd1000000;
    assign lo_bound[m] = CNT_W'(EXPC - TOLC);
    assign hi_bound[m] = CNT_W'(EXPC + TOLC);
  end

  always_comb begin
    verdict.too_low  = gate_total < lo_bound[mode_sel];
    verdict.too_high = gate_total > hi_bound[mode_sel];
  end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_end,
  input  fwd_verdict_t verdict,
  output logic         pd_enable,
  output logic         steer_up,
  output logic         steer_down,
  output logic         locked
);
  fwd_state_e st_q, st_d;
  fwd_dir_e   dir_q, dir_d;
  logic       out_win;

  assign out_win = verdict.too_low | verdict.too_high;

  always_comb begin
    st_d  = st_q;
    dir_d = dir_q;
    if (gate_end) begin
      if (out_win) begin
        st_d  = ST_STEER;
        dir_d = verdict.too_low ? DIR_UP : DIR_DOWN;
      end else begin
        dir_d = DIR_NONE;
        unique case (st_q)
          ST_STEER:   st_d = ST_MEASURE;
          ST_MEASURE: st_d = ST_TRACK;
          ST_TRACK:   st_d = ST_TRACK;
          default:    st_d = ST_STEER;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_STEER;
      dir_q <= DIR_NONE;
    end else if (gate_end) begin
      st_q  <= st_d;
      dir_q <= dir_d;
    end
  end

  assign pd_enable  = (st_q == ST_MEASURE) || (st_q == ST_TRACK);
  assign locked     = (st_q == ST_TRACK);
  assign steer_up   = (st_q == ST_STEER) && (dir_q == DIR_UP);
  assign steer_down = (st_q == ST_STEER) && (dir_q == DIR_DOWN);
endmodule

// File: rtl/freq_window_det.sv
module freq_window_det
  import fwd_pkg::*;
#(
  parameter int GATE_CYCLES = 65536,
  parameter int SLOW_DIV    = 2,
  parameter int FAST_DIV    = 4,
  parameter int TOL_PPM     = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_sel,
  input  logic div_edge,
  output logic pd_enable,
  output logic steer_up,
  output logic steer_down,
  output logic locked
);
  localparam int CNT_W = $clog2(GATE_CYCLES + 1);

  logic             gate_end;
  logic [CNT_W-1:0] gate_total;
  fwd_verdict_t     verdict;
  logic             in_window;

  assign in_window = !(verdict.too_low || verdict.too_high);

  fwd_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_end (gate_end)
  );

  fwd_edge_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_pulse (div_edge),
    .gate_end   (gate_end),
    .gate_total (gate_total)
  );

  fwd_window_cmp #(
    .CNT_W       (CNT_W),
    .GATE_CYCLES (GATE_CYCLES),
    .SLOW_DIV    (SLOW_DIV),
    .FAST_DIV    (FAST_DIV),
    .TOL_PPM     (TOL_PPM)
  ) u_cmp (
    .mode_sel   (ref_sel),
    .gate_total (gate_total),
    .verdict    (verdict)
  );

  fwd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_end   (gate_end),
    .verdict    (verdict),
    .pd_enable  (pd_enable),
    .steer_up   (steer_up),
    .steer_down (steer_down),
    .locked     (locked)
  );
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker (
  input logic clk,
  input logic rst_n,
  input logic gate_end,
  input logic in_window,
  input logic pd_enable,
  input logic steer_up,
  input logic steer_down,
  input logic locked
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!pd_enable && !locked && !steer_up && !steer_down);
    end
  end

  // R9
  steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({steer_up, steer_down}));

  // R9
  steer_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_up || steer_down) |-> !pd_enable);

  // R9
  lock_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> pd_enable);

  // R2
  hold_between_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_end |=> $stable({pd_enable, locked, steer_up, steer_down}));

  // R8
  drop_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end && !in_window) |=> (!pd_enable && !locked && (steer_up || steer_down)));

  // R6
  release_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_end && in_window) |=> (pd_enable && !steer_up && !steer_down));

  // R7
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(pd_enable) && $past(gate_end) && $past(in_window)));
endmodule

bind freq_window_det fwd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gate_end   (gate_end),
  .in_window  (in_window),
  .pd_enable  (pd_enable),
  .steer_up   (steer_up),
  .steer_down (steer_down),
  .locked     (locked)
);

// File: tb/freq_window_det_tb.sv
module freq_window_det_tb;
  localparam int GATE = 256;
  localparam int PPM  = 50000;
  localparam int NV   = 17;

  // {mode, count[8:0], pd_enable, locked, steer_up, steer_down}
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 9'd100, 4'b0010},  // R4 low
    {1'b0, 9'd160, 4'b0001},  // R5 high
    {1'b0, 9'd128, 4'b1000},  // R6 release
    {1'b0, 9'd128, 4'b1100},  // R7 lock
    {1'b0, 9'd122, 4'b1100},  // R3 low edge in
    {1'b0, 9'd134, 4'b1100},  // R3 high edge in
    {1'b0, 9'd135, 4'b0001},  // R8 from lock
    {1'b0, 9'd122, 4'b1000},  // R6
    {1'b0, 9'd121, 4'b0010},  // R8 from measure
    {1'b1, 9'd64,  4'b1000},  // R3 fast mode
    {1'b1, 9'd61,  4'b1100},  // R3 fast low edge
    {1'b1, 9'd67,  4'b1100},  // R3 fast high edge
    {1'b1, 9'd68,  4'b0001},  // R3 fast high out
    {1'b1, 9'd60,  4'b0010},  // R3 fast low out
    {1'b1, 9'd128, 4'b0001},  // R3 slow count in fast mode
    {1'b0, 9'd128, 4'b1000},  // R6
    {1'b0, 9'd0,   4'b0010}   // R4 no edges
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ref_sel = 1'b0;
  logic div_edge = 1'b0;
  logic pd_enable, steer_up, steer_down, locked;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [3:0] prev_exp = 4'b0000;

  always #4 clk = ~clk;

  freq_window_det #(.GATE_CYCLES(GATE), .TOL_PPM(PPM)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_sel    (ref_sel),
    .div_edge   (div_edge),
    .pd_enable  (pd_enable),
    .steer_up   (steer_up),
    .steer_down (steer_down),
    .locked     (locked)
  );

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pd_enable, locked, steer_up, steer_down};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {pd,lock,up,dn} = %b, expected %b", req, act, exp);
    end
  endtask

  // Called between a negedge and the next posedge; returns at a negedge.
  task automatic run_gate(input logic sel_a, input logic sel_b, input int k,
                          input logic [3:0] exp, input string req);
    for (int i = 0; i < GATE; i++) begin
      ref_sel  = (i == GATE - 1) ? sel_b : sel_a;
      div_edge = (i < k);
      @(posedge clk);
      @(negedge clk);
      if (i == GATE / 2) chk("R2 mid-gate hold", prev_exp);
    end
    div_edge = 1'b0;
    chk(req, exp);
    prev_exp = exp;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0000);
    rst_n = 1'b1;
    chk("R1 after release", 4'b0000);
    prev_exp = 4'b0000;

    for (int v = 0; v < NV; v++) begin
      run_gate(VEC[v][13], VEC[v][13], int'(VEC[v][12:4]), VEC[v][3:0],
               $sformatf("R3/R4-R8 vector %0d", v));
    end

    // R10: mode at the closing cycle decides
    run_gate(1'b1, 1'b0, 128, 4'b1000, "R10 switch to slow at gate end");
    run_gate(1'b0, 1'b1, 128, 4'b0001, "R10 switch to fast at gate end");
    run_gate(1'b0, 1'b0, 128, 4'b1000, "R6 re-release");
    run_gate(1'b0, 1'b0, 128, 4'b1100, "R7 relock");

    // R1: asynchronous reset from lock
    #1 rst_n = 1'b0;
    #1 chk("R1 async reset from lock", 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 steering after reset", 4'b0000);
    prev_exp = 4'b0000;
    run_gate(1'b0, 1'b0, 128, 4'b1000, "R2 fresh gate after reset");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule